// File: doc/BRIEF.md
# Multi-Channel Power Enable Sequencer

This block handles push-button power commands for a four-channel power-sourcing controller. A command byte carries one power-on bit and one power-off bit per channel. Each channel decides from the command what to do: switch on at once, start a single detect-then-classify cycle, wait for a cycle already in progress, ignore the request, or switch off and clear its status. That decision depends on the channel's operating mode, its detect-enable and class-enable flags, any fault cool-down, and the wiring of its channel pair. The detection and classification engine sits outside the block. Its results arrive as a done strobe with validity and allocation flags.

The command port takes a write on every cycle that `cmd_valid` is high. It has no back-pressure, and the byte is not stored, so it acts as self-clearing. All outputs are registered. A command sampled at a rising edge shows its effect right after that edge. A done strobe resolves a pending attempt at the edge where it is sampled.

Top module: `pwr_en_seq`

## Requirements
- R1: The command byte is accepted whenever `cmd_valid` is high. Bit 4+i asks for power-off of channel i and bit i asks for power-on of channel i. After reset every output is zero.
- R2: If a single write sets both the power-on bit and the power-off bit of one channel, that channel ends up off, with a clear pulse.
- R3: Mode code 00 (off) ignores power-on requests, drops any pending request and never resolves a cycle.
- R4: While `cooldown[i]` is high, channel i ignores power-on requests, drops any pending request and stays off.
- R5: In mode code 01 (manual), a power-on request raises `pwr_on_o[i]` and `on_pulse_o[i]` at the next edge. No cycle is started.
- R6: In mode 10 (semi-auto) or 11 (auto), when detect-enable and class-enable are not both set, a request pulses `start_pulse_o[i]` and sets `pend_o[i]`. The next `cyc_done[i]` resolves it: power-on with an on pulse if detection, class and allocation are all ok, otherwise a fault pulse. Either way the pending flag clears.
- R7: In semi-auto mode with both enables set, a request only sets `pend_o[i]`. If `cls_busy[i]` is low when the request arrives, the next done strobe resolves it. If it is high, the done strobe that ends the running cycle is skipped and the one after it resolves. Further requests are ignored while the flag is pending.
- R8: In auto mode with both enables set, requests have no effect. Any `cyc_done[i]` with all results ok powers an off channel, provided it is not in cool-down.
- R9: A power-off request works in every mode. At the next edge it drops the channel's power and pending flag and pulses `clr_pulse_o[i]` for that channel only.
- R10: When a pair k (channels 2k and 2k+1) has `pair_4p[k]` and `hi_cls[k]` both set, a power-off request on either channel switches off and clears both channels.
- R11: For such a pair, a power-on request for one channel whose partner has no power-on request in the same write has two outcomes. If the partner is powered, the channel turns on at once. Otherwise the block gives a fault pulse and starts no attempt.
- R12: A power-on request for a channel that is already powered is ignored.
- R13: `on_pulse_o` and `fault_pulse_o` last one cycle and never coincide. An on pulse marks the cycle in which power rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte: off bits [7:4], on bits [3:0] |
| mode_i | input | 8 | Per-channel mode, channel i at [2i+1:2i] |
| det_en | input | 4 | Per-channel detect-enable |
| cls_en | input | 4 | Per-channel class-enable |
| cooldown | input | 4 | Fault cool-down or disconnect in progress |
| cls_busy | input | 4 | Classification currently running |
| cyc_done | input | 4 | Detect/classify cycle finished |
| det_ok | input | 4 | Detection result valid (with cyc_done) |
| cls_ok | input | 4 | Classification result valid (with cyc_done) |
| alloc_ok | input | 4 | Power allocation sufficient |
| pair_4p | input | 2 | Pair wired as four-pair single-signature load |
| hi_cls | input | 2 | Pair's assigned class is 5 or above |
| pwr_on_o | output | 4 | Channel power enabled |
| pend_o | output | 4 | Power-on attempt pending |
| on_pulse_o | output | 4 | Channel powered this cycle |
| fault_pulse_o | output | 4 | Start attempt failed this cycle |
| start_pulse_o | output | 4 | Request one detect/classify cycle |
| clr_pulse_o | output | 4 | Clear this channel's status fields |

## Verification
A wrong pending or arm flag does not show when it goes wrong. It shows at the next done strobe, as an on or fault pulse that is missing, early or extra, or as power that rises one cycle late. Bad priority between off, cool-down and mode shows one edge after the command, as a power bit that stays high or rises. Random commands and done strobes are compared every cycle against a reference model, so a divergence shows up in the cycle it happens. Directed sequences pin down the skip-one-cycle case and the pair cases.

// File: rtl/pwr_en_seq_pkg.sv
package pwr_en_seq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_MANUAL = 2'b01,
    MODE_SEMI   = 2'b10,
    MODE_AUTO   = 2'b11
  } ch_mode_e;

  // Per-channel command after write decode and pair expansion
  typedef struct packed {
    logic off;     // switch off and clear
    logic on_req;  // ordinary power-on request
    logic on_now;  // pair partner already powered: immediate on
    logic on_bad;  // lone request on a high-class pair: fault
  } ch_cmd_t;

endpackage

// File: rtl/pwr_en_seq_decode.sv
module pwr_en_seq_decode
  import pwr_en_seq_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic                  cmd_valid,
  input  logic [2*N_CH-1:0]     cmd_data,
  input  logic [N_CH/2-1:0]     pair_4p,
  input  logic [N_CH/2-1:0]     hi_cls,
  input  logic [N_CH-1:0]       pwr_state,
  output ch_cmd_t [N_CH-1:0]    ch_cmd
);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int P = c ^ 1;
    localparam int K = c / 2;
    logic hi, off_e, on_e, lone;

    assign hi    = pair_4p[K] & hi_cls[K];
    assign off_e = cmd_valid & (cmd_data[N_CH+c] | (hi & cmd_data[N_CH+P]));
    assign on_e  = cmd_valid & cmd_data[c] & ~off_e;
    assign lone  = hi & on_e & ~cmd_data[P];

    assign ch_cmd[c].off    = off_e;
    assign ch_cmd[c].on_req = on_e & ~lone;
    assign ch_cmd[c].on_now = lone & pwr_state[P];
    assign ch_cmd[c].on_bad = lone & ~pwr_state[P];
  end

endmodule

// File: rtl/pwr_en_seq_channel.sv
module pwr_en_seq_channel
  import pwr_en_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ch_mode_e mode,
  input  logic     det_en,
  input  logic     cls_en,
  input  logic     cooldown,
  input  logic     cls_busy,
  input  logic     cyc_done,
  input  logic     det_ok,
  input  logic     cls_ok,
  input  logic     alloc_ok,
  input  ch_cmd_t  cmd,
  output logic     pwr_q,
  output logic     pend_q,
  output logic     on_q,
  output logic     flt_q,
  output logic     st_q,
  output logic     clr_q
);

  logic arm_q;
  logic pwr_n, pend_n, arm_n, on_n, flt_n, st_n, clr_n;
  logic both, res_ok;

  assign both   = det_en & cls_en;
  assign res_ok = det_ok & cls_ok & alloc_ok;

  always_comb begin
    pwr_n  = pwr_q;
    pend_n = pend_q;
    arm_n  = arm_q;
    on_n   = 1'b0;
    flt_n  = 1'b0;
    st_n   = 1'b0;
    clr_n  = 1'b0;
    if (cmd.off) begin
      pwr_n  = 1'b0;
      pend_n = 1'b0;
      arm_n  = 1'b0;
      clr_n  = 1'b1;
    end else if (mode == MODE_OFF || cooldown) begin
      pend_n = 1'b0;
      arm_n  = 1'b0;
    end else if (!pwr_q) begin
      if (pend_q) begin
        if (cyc_done) begin
          if (arm_q) begin
            pend_n = 1'b0;
            arm_n  = 1'b0;
            if (res_ok) begin
              pwr_n = 1'b1;
              on_n  = 1'b1;
            end else begin
              flt_n = 1'b1;
            end
          end else begin
            arm_n = 1'b1;   // running cycle ended; the next one counts
          end
        end
      end else if (cyc_done && mode == MODE_AUTO && both && res_ok) begin
        pwr_n = 1'b1;
        on_n  = 1'b1;
      end else if (cmd.on_now) begin
        pwr_n = 1'b1;
        on_n  = 1'b1;
      end else if (cmd.on_bad) begin
        flt_n = 1'b1;
      end else if (cmd.on_req) begin
        unique case (mode)
          MODE_MANUAL: begin
            pwr_n = 1'b1;
            on_n  = 1'b1;
          end
          MODE_SEMI, MODE_AUTO: begin
            if (!both) begin
              pend_n = 1'b1;
              arm_n  = 1'b1;
              st_n   = 1'b1;
            end else if (mode == MODE_SEMI) begin
              pend_n = 1'b1;
              arm_n  = ~cls_busy;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      on_q   <= 1'b0;
      flt_q  <= 1'b0;
      st_q   <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      pwr_q  <= pwr_n;
      pend_q <= pend_n;
      arm_q  <= arm_n;
      on_q   <= on_n;
      flt_q  <= flt_n;
      st_q   <= st_n;
      clr_q  <= clr_n;
    end
  end

endmodule

// File: rtl/pwr_en_seq.sv
module pwr_en_seq
  import pwr_en_seq_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2*N_CH-1:0]    cmd_data,
  input  logic [2*N_CH-1:0]    mode_i,
  input  logic [N_CH-1:0]      det_en,
  input  logic [N_CH-1:0]      cls_en,
  input  logic [N_CH-1:0]      cooldown,
  input  logic [N_CH-1:0]      cls_busy,
  input  logic [N_CH-1:0]      cyc_done,
  input  logic [N_CH-1:0]      det_ok,
  input  logic [N_CH-1:0]      cls_ok,
  input  logic [N_CH-1:0]      alloc_ok,
  input  logic [N_CH/2-1:0]    pair_4p,
  input  logic [N_CH/2-1:0]    hi_cls,
  output logic [N_CH-1:0]      pwr_on_o,
  output logic [N_CH-1:0]      pend_o,
  output logic [N_CH-1:0]      on_pulse_o,
  output logic [N_CH-1:0]      fault_pulse_o,
  output logic [N_CH-1:0]      start_pulse_o,
  output logic [N_CH-1:0]      clr_pulse_o
);

  localparam int MW = 2;

  ch_cmd_t [N_CH-1:0] ch_cmd;

  pwr_en_seq_decode #(.N_CH(N_CH)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .pair_4p   (pair_4p),
    .hi_cls    (hi_cls),
    .pwr_state (pwr_on_o),
    .ch_cmd    (ch_cmd)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    pwr_en_seq_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (ch_mode_e'(mode_i[MW*i +: MW])),
      .det_en   (det_en[i]),
      .cls_en   (cls_en[i]),
      .cooldown (cooldown[i]),
      .cls_busy (cls_busy[i]),
      .cyc_done (cyc_done[i]),
      .det_ok   (det_ok[i]),
      .cls_ok   (cls_ok[i]),
      .alloc_ok (alloc_ok[i]),
      .cmd      (ch_cmd[i]),
      .pwr_q    (pwr_on_o[i]),
      .pend_q   (pend_o[i]),
      .on_q     (on_pulse_o[i]),
      .flt_q    (fault_pulse_o[i]),
      .st_q     (start_pulse_o[i]),
      .clr_q    (clr_pulse_o[i])
    );
  end

endmodule

// File: rtl/pwr_en_seq_chk.sv
module pwr_en_seq_chk #(
  parameter int N_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2*N_CH-1:0] cmd_data,
  input logic [2*N_CH-1:0] mode_i,
  input logic [N_CH-1:0]   cooldown,
  input logic [N_CH-1:0]   pwr_on_o,
  input logic [N_CH-1:0]   pend_o,
  input logic [N_CH-1:0]   on_pulse_o,
  input logic [N_CH-1:0]   fault_pulse_o,
  input logic [N_CH-1:0]   start_pulse_o,
  input logic [N_CH-1:0]   clr_pulse_o
);

  for (genvar i = 0; i < N_CH; i++) begin : g_a
    AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_data[N_CH+i]) |=> (!pwr_on_o[i] && !pend_o[i] && clr_pulse_o[i])); // R9
    AST_MODE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[2*i +: 2] == 2'b00 && !pwr_on_o[i]) |=> !pwr_on_o[i]); // R3
    AST_COOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cooldown[i] && !pwr_on_o[i]) |=> !pwr_on_o[i]); // R4
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      on_pulse_o[i] |-> !fault_pulse_o[i]); // R13
    AST_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      on_pulse_o[i] |-> (pwr_on_o[i] && !$past(pwr_on_o[i]))); // R13
    AST_START_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse_o[i] |-> (pend_o[i] && !pwr_on_o[i])); // R6
  end

endmodule

bind pwr_en_seq pwr_en_seq_chk #(.N_CH(N_CH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_data      (cmd_data),
  .mode_i        (mode_i),
  .cooldown      (cooldown),
  .pwr_on_o      (pwr_on_o),
  .pend_o        (pend_o),
  .on_pulse_o    (on_pulse_o),
  .fault_pulse_o (fault_pulse_o),
  .start_pulse_o (start_pulse_o),
  .clr_pulse_o   (clr_pulse_o)
);

// File: tb/pwr_en_seq_test.sv
`timescale 1ns/1ps
module pwr_en_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_data = '0;
  logic [7:0] mode_i = '0;
  logic [3:0] det_en = '0, cls_en = '0, cooldown = '0, cls_busy = '0, cyc_done = '0;
  logic [3:0] det_ok = '1, cls_ok = '1, alloc_ok = '1;
  logic [1:0] pair_4p = '0, hi_cls = '0;
  logic [3:0] pwr_on_o, pend_o, on_pulse_o, fault_pulse_o, start_pulse_o, clr_pulse_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwr_en_seq uut (.*);

  // reference state
  bit       mp[4], mpd[4], marm[4];
  logic [3:0] e_pwr, e_pend, e_on, e_flt, e_st, e_clr;

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // expected next state from the requirements, using inputs before the edge
  task automatic model_calc;
    bit np[4], npd[4], na[4];
    for (int c = 0; c < 4; c++) begin
      int p = c ^ 1;
      bit hi   = pair_4p[c/2] & hi_cls[c/2];
      bit off  = cmd_valid & (cmd_data[4+c] | (hi & cmd_data[4+p]));
      bit on   = cmd_valid & cmd_data[c] & !off;
      bit lone = hi & on & !cmd_data[p];
      bit now  = lone & mp[p];
      bit bad  = lone & !mp[p];
      bit req  = on & !lone;
      logic [1:0] md = mode_i[2*c +: 2];
      bit both = det_en[c] & cls_en[c];
      bit ok   = det_ok[c] & cls_ok[c] & alloc_ok[c];
      np[c] = mp[c]; npd[c] = mpd[c]; na[c] = marm[c];
      e_on[c] = 0; e_flt[c] = 0; e_st[c] = 0; e_clr[c] = 0;
      if (off) begin
        np[c] = 0; npd[c] = 0; na[c] = 0; e_clr[c] = 1;
      end else if (md == 2'b00 || cooldown[c]) begin
        npd[c] = 0; na[c] = 0;
      end else if (!mp[c]) begin
        if (mpd[c]) begin
          if (cyc_done[c]) begin
            if (marm[c]) begin
              npd[c] = 0; na[c] = 0;
              if (ok) begin np[c] = 1; e_on[c] = 1; end else e_flt[c] = 1;
            end else na[c] = 1;
          end
        end else if (cyc_done[c] && md == 2'b11 && both && ok) begin
          np[c] = 1; e_on[c] = 1;
        end else if (now) begin
          np[c] = 1; e_on[c] = 1;
        end else if (bad) begin
          e_flt[c] = 1;
        end else if (req) begin
          if (md == 2'b01) begin np[c] = 1; e_on[c] = 1; end
          else if (!both) begin npd[c] = 1; na[c] = 1; e_st[c] = 1; end
          else if (md == 2'b10) begin npd[c] = 1; na[c] = !cls_busy[c]; end
        end
      end
    end
    for (int c = 0; c < 4; c++) begin
      mp[c] = np[c]; mpd[c] = npd[c]; marm[c] = na[c];
      e_pwr[c] = np[c]; e_pend[c] = npd[c];
    end
  endtask

  task automatic step(input bit v, input logic [7:0] d, input logic [3:0] done);
    cmd_valid = v; cmd_data = d; cyc_done = done;
    model_calc();
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; cmd_data = '0; cyc_done = '0;
    chk("R5/R6/R7/R8 pwr_on", pwr_on_o, e_pwr);
    chk("R7 pend", pend_o, e_pend);
    chk("R13 on_pulse", on_pulse_o, e_on);
    chk("R11 fault_pulse", fault_pulse_o, e_flt);
    chk("R6 start_pulse", start_pulse_o, e_st);
    chk("R9 clr_pulse", clr_pulse_o, e_clr);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    int r;
    r = $urandom(32'd2024);
    for (int c = 0; c < 4; c++) begin mp[c] = 0; mpd[c] = 0; marm[c] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset pwr", pwr_on_o, 4'b0000);
    chk("R1 reset pulses", on_pulse_o | fault_pulse_o | start_pulse_o | clr_pulse_o | pend_o, 4'b0000);

    mode_i = 8'h55;                       // all manual
    step(1, 8'h01, 0);
    chk("R5 manual on", pwr_on_o, 4'b0001);
    chk("R5 manual pulse", on_pulse_o | start_pulse_o, 4'b0001);
    step(1, 8'h22, 0);
    chk("R2 on+off same write", pwr_on_o, 4'b0001);
    chk("R2 clear pulse", clr_pulse_o, 4'b0010);
    step(1, 8'h01, 0);
    chk("R12 already on", on_pulse_o, 4'b0000);
    step(1, 8'h10, 0);
    chk("R9 power off", pwr_on_o, 4'b0000);
    chk("R9 clear only ch0", clr_pulse_o, 4'b0001);
    mode_i = 8'h51;                       // ch1 off mode
    step(1, 8'h02, 0);
    chk("R3 off mode ignores", pwr_on_o | on_pulse_o, 4'b0000);
    cooldown = 4'b0100;
    step(1, 8'h04, 0);
    chk("R4 cooldown ignores", pwr_on_o | on_pulse_o, 4'b0000);
    cooldown = 0;

    mode_i = 8'h91;                       // ch3 semi, enables clear
    step(1, 8'h08, 0);
    chk("R6 start", start_pulse_o, 4'b1000);
    chk("R6 pending", pend_o, 4'b1000);
    step(0, 0, 4'b1000);
    chk("R6 resolved on", on_pulse_o & pwr_on_o, 4'b1000);
    step(1, 8'h80, 0);
    step(1, 8'h08, 0);
    det_ok = 4'b0111;
    step(0, 0, 4'b1000);
    chk("R6 invalid fails", fault_pulse_o, 4'b1000);
    chk("R6 stays off", pwr_on_o | pend_o, 4'b0000);
    det_ok = '1;

    det_en = 4'b1000; cls_en = 4'b1000; cls_busy = 4'b1000;
    step(1, 8'h08, 0);
    chk("R7 latched no start", pend_o | (start_pulse_o << 0), 4'b1000);
    cls_busy = 0;
    step(0, 0, 4'b1000);
    chk("R7 running cycle skipped", pwr_on_o, 4'b0000);
    chk("R7 still pending", pend_o, 4'b1000);
    step(0, 0, 4'b1000);
    chk("R7 next cycle powers", on_pulse_o, 4'b1000);
    step(1, 8'h80, 0);

    mode_i = 8'hD1;                       // ch3 auto, both enables
    step(1, 8'h08, 0);
    chk("R8 request no effect", pend_o | start_pulse_o | pwr_on_o, 4'b0000);
    step(0, 0, 4'b1000);
    chk("R8 auto powers", pwr_on_o & on_pulse_o, 4'b1000);
    step(1, 8'h80, 0);
    det_en = 0; cls_en = 0;

    mode_i = 8'h55; pair_4p = 2'b01; hi_cls = 2'b01;
    step(1, 8'h01, 0);
    chk("R11 lone request fault", fault_pulse_o, 4'b0001);
    chk("R11 no power", pwr_on_o, 4'b0000);
    step(1, 8'h03, 0);
    chk("R11 pair request powers both", pwr_on_o, 4'b0011);
    step(1, 8'h10, 0);
    chk("R10 off drops both", pwr_on_o, 4'b0000);
    chk("R10 clear both", clr_pulse_o, 4'b0011);
    hi_cls = 0;
    step(1, 8'h02, 0);
    hi_cls = 2'b01;
    step(1, 8'h01, 0);
    chk("R11 partner on immediate", on_pulse_o, 4'b0001);
    step(1, 8'h20, 0);
    chk("R10 off from partner", pwr_on_o, 4'b0000);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] dn;
      if (n % 250 == 0) begin
        mode_i  = 8'($urandom);
        pair_4p = 2'($urandom);
        hi_cls  = 2'($urandom);
      end
      if ($urandom % 32 == 0) det_en = 4'($urandom);
      if ($urandom % 32 == 0) cls_en = 4'($urandom);
      cooldown = 4'($urandom & $urandom & $urandom & $urandom);
      cls_busy = 4'($urandom);
      det_ok   = 4'($urandom | $urandom);
      cls_ok   = 4'($urandom | $urandom);
      alloc_ok = 4'($urandom | $urandom);
      dn = 4'($urandom & $urandom);
      step(($urandom % 4) == 0, 8'($urandom), dn);
    end
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

endmodule